// File: doc/BRIEF.md
# Attribute-coloured pixel serializer

This block sits between a video memory fetch path and the colour outputs of a raster display. At each scanline start it runs a schedule of byte fetches: one bitmap byte per character column, and, in the attribute modes, extra attribute bytes placed in idle fetch slots. It shifts the returned bitmap bytes out as pixels, repeating each pixel 1, 2, 3 or 4 times, and colours every 1-bit pixel with a foreground or background colour taken from the attribute of its character.

Attribute bytes are fetched only on the first pixel row of a character row. They are written into a small buffer and read back on the remaining pixel rows. A byte can serve one character (foreground and background from its two nibbles) or two characters (one nibble each). Pixel output starts eight slots after the first fetch, so the attribute of the first column is in place before that column's pixels begin. Memory arbitration is not part of this block. The memory must return data exactly one cycle after each request.

Top module: `attr_pixel_serializer`

## Requirements
- R1: While reset is held and after it is released, with no line started, `fetch_req` is 0, `pix_active` is 0 and `rgb` is 0.
- R2: Slot 0 is the first cycle after `line_start` is sampled high. With repeat factor k = `scale`+1, the column count is floor(640/(8k)): 80, 40, 26 or 20. For each column c, a bitmap fetch (`fetch_req`=1, `fetch_attr`=0, `fetch_col`=c) is issued in slot 8k·c and in no other slot.
- R3: The data for a request is taken from `fetch_data` in the cycle after the request.
- R4: `pix_active` is 1 in exactly slots 8 through 8 + columns·8k − 1. Outside that window `rgb` is 0.
- R5: Each bitmap byte is sent most significant bit first, and each pixel is held for k consecutive slots.
- R6: At k=3 there are 26 columns and 624 active slots, which leaves 16 of the 640 pixel slots blank at the end of the line.
- R7: On a first-row line in an attribute mode with k≥2, an attribute fetch (`fetch_attr`=1) is issued in slot 8k·c+4. In per-character mode (`attr_mode`=1) this happens for every column. In shared mode (`attr_mode`=2) it happens for even columns only.
- R8: In per-character mode the attribute byte a gives foreground a[6:4] and background a[2:0]. A pixel bit of 1 selects the foreground and a bit of 0 selects the background.
- R9: In shared mode one byte serves columns 2p and 2p+1. The even column uses nibble a[7:4] and the odd column uses nibble a[3:0]. For a nibble n, the foreground is n[2:0] and the background is the bitwise inverse of n[2:0] when n[3]=1, otherwise 0.
- R10: On a line whose `first_row` is 0, no attribute fetch is issued. The colours come from the attribute bytes buffered by the most recent first-row line.
- R11: In mono mode (`attr_mode` 0 or 3), and in any mode at k=1, no attribute fetch is issued, the foreground is 7 and the background is 0.
- R12: `scale`, `attr_mode` and `first_row` are sampled only when `line_start` is high. Changing them during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one pixel slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Begins a scanline and samples the configuration |
| scale | input | 2 | Pixel repeat factor minus one |
| attr_mode | input | 2 | 0 mono, 1 per-character attribute, 2 shared attribute, 3 mono |
| first_row | input | 1 | Line is the first pixel row of a character row |
| fetch_req | output | 1 | Fetch request for this slot |
| fetch_attr | output | 1 | Request is for an attribute byte |
| fetch_col | output | 7 | Character column of the request |
| fetch_data | input | 8 | Returned byte, one cycle after the request |
| pix_active | output | 1 | Pixel window is open |
| rgb | output | 3 | Pixel colour, {red, green, blue} |

## Verification
Lines are run at each repeat factor, in mono, per-character and shared-attribute modes, on first-row and later-row lines. Each column has a different bitmap byte and a different attribute, so the tests can tell apart a swapped nibble, a wrong column index and a misplaced pixel. Later-row lines are served by a memory whose attribute values differ from those of the first-row line, so a colour taken from anything but the buffer shows up as a mismatch. One line changes all three configuration inputs halfway through, which exposes any sampling outside `line_start`.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [1:0] {
    AM_MONO  = 2'd0,
    AM_BYTE  = 2'd1,
    AM_PAIR  = 2'd2,
    AM_SPARE = 2'd3
  } attr_mode_t;

  localparam int unsigned PIX_PER_BYTE = 8;

  // Number of character columns that fit the active width at a repeat factor.
  function automatic int unsigned cols_for(input logic [1:0] sc, input int unsigned active);
    case (sc)
      2'd0:    cols_for = active / (PIX_PER_BYTE * 1);
      2'd1:    cols_for = active / (PIX_PER_BYTE * 2);
      2'd2:    cols_for = active / (PIX_PER_BYTE * 3);
      default: cols_for = active / (PIX_PER_BYTE * 4);
    endcase
  endfunction

endpackage

// File: rtl/pxs_fetch_timer.sv
module pxs_fetch_timer #(
  parameter int unsigned ACTIVE_SLOTS = 640,
  parameter int unsigned COL_W        = 7,
  parameter int unsigned PH_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       cfg_scale,
  input  logic             attr_on,
  input  logic             pair_mode,
  input  logic             first_row,
  output logic             fetch_req,
  output logic             fetch_attr,
  output logic [COL_W-1:0] fetch_col,
  output logic             load_now
);

  logic [PH_W-1:0]  ph_q, ph_d, ph_last;
  logic [COL_W-1:0] col_q, col_d, col_last;
  logic             run_q, run_d;
  logic             adv_en;
  logic             bm_slot, at_slot;

  // Last phase of a character period is 8k-1 = 8*scale + 7.
  assign ph_last  = PH_W'({cfg_scale, 3'b111});
  assign col_last = COL_W'(pxs_pkg::cols_for(cfg_scale, ACTIVE_SLOTS) - 1);
  assign adv_en   = line_start | run_q;

  always_comb begin
    ph_d  = ph_q;
    col_d = col_q;
    run_d = run_q;
    if (line_start) begin
      ph_d  = '0;
      col_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (ph_q == ph_last) begin
        ph_d = '0;
        if (col_q == col_last) run_d = 1'b0;
        else                   col_d = col_q + 1'b1;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      col_q <= '0;
      run_q <= 1'b0;
    end else if (adv_en) begin
      ph_q  <= ph_d;
      col_q <= col_d;
      run_q <= run_d;
    end
  end

  assign bm_slot    = run_q && (ph_q == '0);
  assign at_slot    = run_q && attr_on && first_row && (ph_q == PH_W'(4)) &&
                      (!pair_mode || !col_q[0]);
  assign fetch_req  = bm_slot | at_slot;
  assign fetch_attr = at_slot;
  assign fetch_col  = col_q;
  assign load_now   = run_q && (ph_q == PH_W'(7));

endmodule

// File: rtl/pxs_attr_buf.sv
module pxs_attr_buf #(
  parameter int unsigned DEPTH = 40,
  parameter int unsigned AW    = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       wr_ok, rd_ok;

  assign wr_ok = wr_en && ({1'b0, wr_idx} < LIMIT);
  assign rd_ok = {1'b0, rd_idx} < LIMIT;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_idx] <= wr_byte;
  end

  assign rd_byte = rd_ok ? mem[rd_idx] : 8'h00;

endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       load,
  input  logic [7:0] load_bits,
  input  logic [2:0] load_fg,
  input  logic [2:0] load_bg,
  input  logic [1:0] scale,
  output logic [2:0] rgb,
  output logic       active
);

  logic [7:0] sr_q, sr_d;
  logic [2:0] fg_q, fg_d, bg_q, bg_d;
  logic [1:0] sub_q, sub_d;
  logic [2:0] bit_q, bit_d;
  logic       on_q, on_d;
  logic       step_en;

  assign step_en = clear | load | on_q;

  always_comb begin
    sr_d  = sr_q;
    fg_d  = fg_q;
    bg_d  = bg_q;
    sub_d = sub_q;
    bit_d = bit_q;
    on_d  = on_q;
    if (clear) begin
      on_d = 1'b0;
    end else if (load) begin
      sr_d  = load_bits;
      fg_d  = load_fg;
      bg_d  = load_bg;
      sub_d = '0;
      bit_d = '0;
      on_d  = 1'b1;
    end else if (on_q) begin
      if (sub_q == scale) begin
        sub_d = '0;
        sr_d  = {sr_q[6:0], 1'b0};
        if (bit_q == 3'd7) on_d = 1'b0;
        else               bit_d = bit_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
      sub_q <= '0;
      bit_q <= '0;
      on_q  <= 1'b0;
    end else if (step_en) begin
      sr_q  <= sr_d;
      fg_q  <= fg_d;
      bg_q  <= bg_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      on_q  <= on_d;
    end
  end

  assign active = on_q;
  assign rgb    = on_q ? (sr_q[7] ? fg_q : bg_q) : 3'b000;

endmodule

// File: rtl/attr_pixel_serializer.sv
module attr_pixel_serializer #(
  parameter int unsigned ACTIVE_SLOTS = 640,
  parameter int unsigned ATTR_DEPTH   = 40,
  localparam int unsigned COL_W       = $clog2(ACTIVE_SLOTS / 8 + 1),
  localparam int unsigned PH_W        = 5,
  localparam int unsigned AIDX_W      = $clog2(ATTR_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       scale,
  input  logic [1:0]       attr_mode,
  input  logic             first_row,
  output logic             fetch_req,
  output logic             fetch_attr,
  output logic [COL_W-1:0] fetch_col,
  input  logic [7:0]       fetch_data,
  output logic             pix_active,
  output logic [2:0]       rgb
);

  import pxs_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  // Line configuration, sampled at line start.
  logic [1:0] cfg_scale;
  attr_mode_t cfg_mode;
  logic       cfg_first;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cfg_scale <= '0;
      cfg_mode  <= AM_MONO;
      cfg_first <= 1'b0;
    end else if (line_start) begin
      cfg_scale <= scale;
      cfg_mode  <= attr_mode_t'(attr_mode);
      cfg_first <= first_row;
    end
  end

  logic pair_mode, attr_on;
  assign pair_mode = (cfg_mode == AM_PAIR);
  assign attr_on   = ((cfg_mode == AM_BYTE) || pair_mode) && (cfg_scale != 2'd0);

  logic load_now;

  pxs_fetch_timer #(
    .ACTIVE_SLOTS(ACTIVE_SLOTS),
    .COL_W       (COL_W),
    .PH_W        (PH_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .line_start(line_start),
    .cfg_scale (cfg_scale),
    .attr_on   (attr_on),
    .pair_mode (pair_mode),
    .first_row (cfg_first),
    .fetch_req (fetch_req),
    .fetch_attr(fetch_attr),
    .fetch_col (fetch_col),
    .load_now  (load_now)
  );

  // Buffer index of the current column: one entry per column or per column pair.
  logic [COL_W-1:0]  col_idx;
  logic [AIDX_W-1:0] aidx;
  assign col_idx = pair_mode ? {1'b0, fetch_col[COL_W-1:1]} : fetch_col;
  assign aidx    = AIDX_W'(col_idx);

  // Returned-data capture, one cycle after each request.
  logic              bm_pend_q, bm_pend_d, at_pend_q, at_pend_d;
  logic [AIDX_W-1:0] at_idx_q;
  logic [7:0]        bm_hold_q;

  assign bm_pend_d = fetch_req & ~fetch_attr;
  assign at_pend_d = fetch_attr;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      bm_pend_q <= 1'b0;
      at_pend_q <= 1'b0;
      at_idx_q  <= '0;
    end else begin
      bm_pend_q <= bm_pend_d;
      at_pend_q <= at_pend_d;
      if (fetch_attr) at_idx_q <= aidx;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)    bm_hold_q <= '0;
    else if (bm_pend_q) bm_hold_q <= fetch_data;
  end

  logic [7:0] attr_byte;

  pxs_attr_buf #(
    .DEPTH(ATTR_DEPTH),
    .AW   (AIDX_W)
  ) u_abuf (
    .clk    (clk),
    .wr_en  (at_pend_q),
    .wr_idx (at_idx_q),
    .wr_byte(fetch_data),
    .rd_idx (aidx),
    .rd_byte(attr_byte)
  );

  // Colour selection for the column about to be shown.
  logic [3:0] nib;
  logic [2:0] fg, bg;

  assign nib = fetch_col[0] ? attr_byte[3:0] : attr_byte[7:4];

  always_comb begin
    fg = 3'b111;
    bg = 3'b000;
    if (attr_on) begin
      if (pair_mode) begin
        fg = nib[2:0];
        bg = nib[3] ? ~nib[2:0] : 3'b000;
      end else begin
        fg = attr_byte[6:4];
        bg = attr_byte[2:0];
      end
    end
  end

  pxs_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clear    (line_start),
    .load     (load_now),
    .load_bits(bm_hold_q),
    .load_fg  (fg),
    .load_bg  (bg),
    .scale    (cfg_scale),
    .rgb      (rgb),
    .active   (pix_active)
  );

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
  parameter int unsigned ACTIVE_SLOTS = 640,
  parameter int unsigned COL_W        = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             fetch_req,
  input logic             fetch_attr,
  input logic [COL_W-1:0] fetch_col,
  input logic             pix_active,
  input logic [2:0]       rgb,
  input logic [1:0]       cfg_scale
);

  logic [COL_W:0] ncols;
  assign ncols = (COL_W+1)'(pxs_pkg::cols_for(cfg_scale, ACTIVE_SLOTS));

  assert_attr_is_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_attr |-> fetch_req);

  assert_blank_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |-> (rgb == 3'b000));

  assert_no_attr_at_x1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_attr |-> (cfg_scale != 2'd0));

  assert_col_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> ({1'b0, fetch_col} < ncols));

  assert_fetch_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !line_start) |=> !fetch_req);

endmodule

bind attr_pixel_serializer pxs_checker #(
  .ACTIVE_SLOTS(ACTIVE_SLOTS),
  .COL_W       (COL_W)
) u_pxs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_start(line_start),
  .fetch_req (fetch_req),
  .fetch_attr(fetch_attr),
  .fetch_col (fetch_col),
  .pix_active(pix_active),
  .rgb       (rgb),
  .cfg_scale (cfg_scale)
);

// File: tb/test_attr_pixel_serializer.sv
module test_attr_pixel_serializer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       line_start;
  logic [1:0] scale;
  logic [1:0] attr_mode;
  logic       first_row;
  logic       fetch_req;
  logic       fetch_attr;
  logic [6:0] fetch_col;
  logic [7:0] fetch_data;
  logic       pix_active;
  logic [2:0] rgb;

  always #5 clk = ~clk;

  attr_pixel_serializer i_attr_pixel_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_start(line_start),
    .scale     (scale),
    .attr_mode (attr_mode),
    .first_row (first_row),
    .fetch_req (fetch_req),
    .fetch_attr(fetch_attr),
    .fetch_col (fetch_col),
    .fetch_data(fetch_data),
    .pix_active(pix_active),
    .rgb       (rgb)
  );

  int         n_checks = 0;
  int         n_fail   = 0;
  bit         done     = 0;
  string      cur_tag  = "R1";
  logic [2:0] exp_q[$];
  logic [7:0] attr_model [40];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bm_val(input int c, input int seed);
    return 8'((c * 37 + seed * 11 + 5) ^ (seed << 4));
  endfunction

  function automatic logic [7:0] attr_val(input int i, input int seed);
    return 8'(i * 53 + seed * 29 + 19);
  endfunction

  // Monitor: pops one expected colour per active slot.
  always @(negedge clk) begin
    if (rst_n && pix_active) begin
      if (exp_q.size() == 0) begin
        check(1'b0, {cur_tag, " unexpected pixel"}, int'(rgb), -1);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(rgb == e, {cur_tag, " pixel colour"}, int'(rgb), int'(e));
      end
    end
  end

  // Driver: computes expected pixels, starts a line, answers fetches, checks timing.
  task automatic run_line(input int sc, input int mode, input bit first, input int seed,
                          input bit disturb, input string tag);
    int k, cols, per, n_act;
    bit use_attr;
    k        = sc + 1;
    per      = 8 * k;
    cols     = 640 / per;
    use_attr = ((mode == 1) || (mode == 2)) && (sc != 0);
    cur_tag  = tag;
    if (use_attr && first) begin
      int n;
      n = (mode == 1) ? cols : (cols + 1) / 2;
      for (int i = 0; i < n; i++) attr_model[i] = attr_val(i, seed);
    end
    for (int c = 0; c < cols; c++) begin
      logic [7:0] b, a;
      logic [3:0] nb;
      logic [2:0] fg, bg;
      b  = bm_val(c, seed);
      fg = 3'd7;
      bg = 3'd0;
      if (use_attr) begin
        if (mode == 1) begin
          a  = attr_model[c];
          fg = a[6:4];
          bg = a[2:0];
        end else begin
          a  = attr_model[c / 2];
          nb = (c % 2 == 0) ? a[7:4] : a[3:0];
          fg = nb[2:0];
          bg = nb[3] ? ~nb[2:0] : 3'd0;
        end
      end
      for (int bi = 7; bi >= 0; bi--)
        for (int r = 0; r < k; r++) exp_q.push_back(b[bi] ? fg : bg);
    end
    @(negedge clk);
    scale      = 2'(sc);
    attr_mode  = 2'(mode);
    first_row  = first;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    n_act      = 0;
    for (int s = 0; s < 1024; s++) begin
      bit in_f, ebm, eat, eact;
      int ph, c;
      if (disturb && s == 100) begin
        scale     = ~scale;
        attr_mode = 2'd1;
        first_row = ~first_row;
      end
      in_f = s < cols * per;
      ph   = s % per;
      c    = s / per;
      ebm  = in_f && (ph == 0);
      eat  = in_f && use_attr && first && (ph == 4) && ((mode == 1) || (c % 2 == 0));
      eact = (s >= 8) && (s < 8 + cols * per);
      check(fetch_req == (ebm || eat), {tag, " fetch_req"}, int'(fetch_req), int'(ebm || eat));
      check(fetch_attr == eat, {tag, " fetch_attr"}, int'(fetch_attr), int'(eat));
      if (ebm || eat) check(int'(fetch_col) == c, {tag, " fetch_col"}, int'(fetch_col), c);
      check(pix_active == eact, {tag, " R4 window"}, int'(pix_active), int'(eact));
      if (pix_active) n_act++;
      if (fetch_req) begin
        if (fetch_attr) fetch_data = attr_val((mode == 2) ? int'(fetch_col) / 2 : int'(fetch_col), seed);
        else            fetch_data = bm_val(int'(fetch_col), seed);
      end
      @(negedge clk);
    end
    check(n_act == cols * per, {tag, " active slot count"}, n_act, cols * per);
    check(exp_q.size() == 0, {tag, " pixels left over"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    line_start = 1'b0;
    scale      = 2'd0;
    attr_mode  = 2'd0;
    first_row  = 1'b0;
    fetch_data = 8'h00;
    repeat (3) @(negedge clk);
    check(!fetch_req && !pix_active && rgb == 3'd0, "R1 in reset",
          int'({fetch_req, pix_active, rgb}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(fetch_req == 1'b0, "R1 fetch_req idle", int'(fetch_req), 0);
    check(pix_active == 1'b0, "R1 pix_active idle", int'(pix_active), 0);
    check(rgb == 3'd0, "R1 rgb idle", int'(rgb), 0);

    run_line(0, 0, 1'b1, 1, 1'b0, "R2 R3 R4 R5");
    run_line(1, 1, 1'b1, 2, 1'b0, "R7 R8");
    run_line(1, 1, 1'b0, 3, 1'b0, "R10 R8");
    run_line(2, 2, 1'b1, 4, 1'b0, "R6 R7 R9");
    run_line(2, 2, 1'b0, 5, 1'b0, "R6 R9 R10");
    run_line(3, 0, 1'b1, 6, 1'b0, "R4 R5 R11");
    run_line(0, 1, 1'b1, 7, 1'b0, "R11 x1 attr");
    run_line(3, 2, 1'b1, 8, 1'b1, "R12 R9");
    run_line(1, 1, 1'b0, 9, 1'b0, "R10 mixed buffer");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule